// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32 (64 or 96 pins). Its registers are grouped by function. Each function fills a bank of 32-bit words, and bit `p mod 32` of word `p / 32` belongs to pin `p`. Software changes output levels through separate write-one-to-set and write-one-to-clear words, so it never needs a read-modify-write to drive a pin. The direction, edge-enable and alternate-function banks are ordinary read/write storage.

Each input goes through a two-flop synchroniser. The synchronised value feeds the level bank and a per-pin edge detector. Rising and falling detection are enabled independently. A detected edge sets a sticky status bit, and software clears it by writing a one. The interrupt output is the OR of all status bits. Each pin also has a 2-bit alternate-function field. The field is stored and brought out, and the value 0 means plain GPIO.

Access is a single-cycle register bus: a byte address, write data, a write strobe and combinational read data.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe`, `pin_out` and `altfn_sel` are all 0, and `irq` is low.
- R2: The byte address of word `w` of bank `b` is `b*NREG*4 + w*4`, with `NREG = NUM_PINS/32`. The bank order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function.
- R3: Writing a word of the set bank drives `pin_out` high, from the next clock, for every pin whose bit is 1. Pins whose bit is 0 keep their value. Reads of the set bank return 0.
- R4: Writing a word of the clear bank drives `pin_out` low, from the next clock, for every pin whose bit is 1. Pins whose bit is 0 keep their value. Reads of the clear bank return 0.
- R5: The direction bank reads back what was written. A direction bit of 1 raises the matching `pin_oe` bit (output), and 0 leaves the pin an input.
- R6: The level bank shows `pin_in` after two clock edges of synchronisation.
- R7: With its rising-enable bit set, a 0-to-1 change on `pin_in[p]` sets status bit `p` on the third clock edge after the change. With the bit clear, no status is set.
- R8: A falling-enable bit detects 1-to-0 changes in the same way. With both enables set, both edges are detected.
- R9: Writing 1 to a status bit clears it, and zero bits leave their status unchanged. An edge detected in the same cycle as the clear write leaves the bit set.
- R10: `irq` is high while any status bit is set and drops once all status bits are cleared.
- R11: Pin `p` owns bits `[2(p mod 16)+1 : 2(p mod 16)]` of word `p/16` in the alternate-function bank. The field reads back and appears at `altfn_sel[2p+1:2p]`.
- R12: Writes to the level bank have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable (direction) |
| altfn_sel | output | 2*NUM_PINS | Alternate-function field per pin |
| irq | output | 1 | Level interrupt, OR of all status bits |

## Verification
Two functions can meet in one cycle: the detection of a synchronised edge and a software write-one-to-clear of the same status bit. The bench provokes the collision by timing a falling input so that the edge event is live during the clock that commits the clear write. The bit must then read back as set and `irq` must stay high. A separate pass clears the same bit with no edge present and expects it to drop.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    BK_LEVEL = 3'd0,
    BK_DIR   = 3'd1,
    BK_SET   = 3'd2,
    BK_CLR   = 3'd3,
    BK_RISE  = 3'd4,
    BK_FALL  = 3'd5,
    BK_STAT  = 3'd6,
    BK_ALTFN = 3'd7
  } bank_e;

  typedef struct packed {
    logic       hit;
    bank_e      bank;
    logic [7:0] word;
  } dec_t;

  // Splits a byte address into bank and word index. The alternate-function
  // bank is twice as long as the others and is the last one in the map.
  function automatic dec_t decode_addr(input int unsigned byte_addr,
                                       input int unsigned nreg);
    int unsigned raw;
    dec_t d;
    d   = '0;
    raw = byte_addr / (nreg * 4);
    if (raw < 7) begin
      d.hit  = 1'b1;
      d.bank = bank_e'(raw[2:0]);
      d.word = 8'((byte_addr % (nreg * 4)) / 4);
    end else if (raw < 9) begin
      d.hit  = 1'b1;
      d.bank = BK_ALTFN;
      d.word = 8'((byte_addr - 7 * nreg * 4) / 4);
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] evt,
  output logic [WIDTH-1:0] status
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] rose;
  logic [WIDTH-1:0] fell;

  assign rose = lvl & ~prev_q;
  assign fell = ~lvl & prev_q;
  assign evt  = (rose & rise_en) | (fell & fall_en);

  // New events win over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl;
      status_q <= (status_q & ~clr_mask) | evt;
    end
  end

  assign status = status_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  bank_e                 wr_bank,
  input  logic [7:0]            wr_word,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [NUM_PINS-1:0]   set_mask,
  input  logic [NUM_PINS-1:0]   clr_mask,
  output logic [NUM_PINS-1:0]   dir_q,
  output logic [NUM_PINS-1:0]   out_q,
  output logic [NUM_PINS-1:0]   rise_en_q,
  output logic [NUM_PINS-1:0]   fall_en_q,
  output logic [2*NUM_PINS-1:0] altfn_q
);

  localparam int unsigned NREG    = NUM_PINS / WORD_W;
  localparam int unsigned AF_WORDS = 2 * NREG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      altfn_q   <= '0;
    end else begin
      out_q <= (out_q | set_mask) & ~clr_mask;
      if (wr_en) begin
        for (int w = 0; w < NREG; w++) begin
          if (wr_word == 8'(w)) begin
            case (wr_bank)
              BK_DIR:  dir_q[w*WORD_W +: WORD_W]     <= wr_data;
              BK_RISE: rise_en_q[w*WORD_W +: WORD_W] <= wr_data;
              BK_FALL: fall_en_q[w*WORD_W +: WORD_W] <= wr_data;
              default: ;
            endcase
          end
        end
        if (wr_bank == BK_ALTFN) begin
          for (int w = 0; w < AF_WORDS; w++) begin
            if (wr_word == 8'(w)) altfn_q[w*WORD_W +: WORD_W] <= wr_data;
          end
        end
      end
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned ADDR_W   = $clog2(36 * (NUM_PINS / 32))
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_we,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [2*NUM_PINS-1:0] altfn_sel,
  output logic                  irq
);

  localparam int unsigned NREG     = NUM_PINS / WORD_W;
  localparam int unsigned AF_WORDS = 2 * NREG;

  dec_t dec;
  logic wr_hit;

  // Named internal events, observed by the bound checker.
  logic [NUM_PINS-1:0] set_mask;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] stat_clr_mask;
  logic [NUM_PINS-1:0] edge_evt;
  logic [NUM_PINS-1:0] edge_status;

  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] rise_en_q;
  logic [NUM_PINS-1:0] fall_en_q;
  logic [2*NUM_PINS-1:0] altfn_q;

  assign dec    = decode_addr(32'(bus_addr), NREG);
  assign wr_hit = bus_we & dec.hit;

  for (genvar w = 0; w < NREG; w++) begin : g_word_masks
    logic sel;
    assign sel = wr_hit && (dec.word == 8'(w));
    assign set_mask[w*WORD_W +: WORD_W]      = (sel && dec.bank == BK_SET)  ? bus_wdata : '0;
    assign clr_mask[w*WORD_W +: WORD_W]      = (sel && dec.bank == BK_CLR)  ? bus_wdata : '0;
    assign stat_clr_mask[w*WORD_W +: WORD_W] = (sel && dec.bank == BK_STAT) ? bus_wdata : '0;
  end

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pin_in),
    .sync_out (lvl_sync)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_hit),
    .wr_bank   (dec.bank),
    .wr_word   (dec.word),
    .wr_data   (bus_wdata),
    .set_mask  (set_mask),
    .clr_mask  (clr_mask),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .rise_en_q (rise_en_q),
    .fall_en_q (fall_en_q),
    .altfn_q   (altfn_q)
  );

  gpio_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_sync),
    .rise_en  (rise_en_q),
    .fall_en  (fall_en_q),
    .clr_mask (stat_clr_mask),
    .evt      (edge_evt),
    .status   (edge_status)
  );

  always_comb begin
    bus_rdata = '0;
    if (dec.hit) begin
      if (dec.bank == BK_ALTFN) begin
        for (int w = 0; w < AF_WORDS; w++) begin
          if (dec.word == 8'(w)) bus_rdata = altfn_q[w*WORD_W +: WORD_W];
        end
      end else begin
        for (int w = 0; w < NREG; w++) begin
          if (dec.word == 8'(w)) begin
            case (dec.bank)
              BK_LEVEL: bus_rdata = lvl_sync[w*WORD_W +: WORD_W];
              BK_DIR:   bus_rdata = dir_q[w*WORD_W +: WORD_W];
              BK_RISE:  bus_rdata = rise_en_q[w*WORD_W +: WORD_W];
              BK_FALL:  bus_rdata = fall_en_q[w*WORD_W +: WORD_W];
              BK_STAT:  bus_rdata = edge_status[w*WORD_W +: WORD_W];
              default:  bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end

  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign altfn_sel = altfn_q;
  assign irq       = |edge_status;

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned NUM_PINS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] set_mask,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] stat_clr_mask,
  input logic [NUM_PINS-1:0] edge_evt,
  input logic [NUM_PINS-1:0] edge_status,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq
);

  p_set_drives_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((pin_out & $past(set_mask)) == $past(set_mask)));

  p_clr_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((pin_out & $past(clr_mask)) == '0));

  p_out_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(pin_out));

  p_event_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((edge_status & $past(edge_evt)) == $past(edge_evt)));

  p_status_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt == '0 && stat_clr_mask == '0) |=> $stable(edge_status));

  p_event_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> irq);

  p_clear_all_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt == '0 && ((edge_status & ~stat_clr_mask) == '0)) |=> !irq);

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .set_mask      (set_mask),
  .clr_mask      (clr_mask),
  .stat_clr_mask (stat_clr_mask),
  .edge_evt      (edge_evt),
  .edge_status   (edge_status),
  .pin_out       (pin_out),
  .irq           (irq)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

  localparam int unsigned NP     = 64;
  localparam int unsigned NREG   = NP / 32;
  localparam int unsigned ADDR_W = $clog2(36 * NREG);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     pin_in = '0;
  logic [NP-1:0]     pin_out;
  logic [NP-1:0]     pin_oe;
  logic [2*NP-1:0]   altfn_sel;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .altfn_sel (altfn_sel),
    .irq       (irq)
  );

  // Bank numbers: 0 level, 1 dir, 2 set, 3 clr, 4 rise, 5 fall, 6 status, 7 altfn
  function automatic logic [ADDR_W-1:0] ra(input int bank, input int word);
    return ADDR_W'(bank * NREG * 4 + word * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int word, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = ra(bank, word);
    bus_wdata = data;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int bank, input int word, output logic [31:0] data);
    bus_addr = ra(bank, word);
    #1;
    data = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int b = 0; b < 7; b++)
      for (int w = 0; w < NREG; w++) begin
        rd(b, w, v); chk("R1 bank reset", v, 32'h0);
      end
    for (int w = 0; w < 2 * NREG; w++) begin
      rd(7, w, v); chk("R1 altfn reset", v, 32'h0);
    end
    chk("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32], 32'h0);
    chk("R1 pin_out", pin_out[31:0] | pin_out[63:32], 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_direction;
    logic [31:0] v;
    wr(1, 1, 32'hA5A5_0001);
    rd(1, 1, v);  chk("R5 dir readback", v, 32'hA5A5_0001);
    rd(1, 0, v);  chk("R2 dir word0 untouched", v, 32'h0);
    chk("R5 pin_oe upper", pin_oe[63:32], 32'hA5A5_0001);
    chk("R5 pin_oe lower", pin_oe[31:0], 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(2, 0, 32'h0000_00F0);
    chk("R3 set word0", pin_out[31:0], 32'h0000_00F0);
    wr(2, 1, 32'h0000_0001);
    chk("R3 set word1", pin_out[63:32], 32'h0000_0001);
    chk("R3 word0 kept", pin_out[31:0], 32'h0000_00F0);
    wr(3, 0, 32'h0000_0030);
    chk("R4 clear word0", pin_out[31:0], 32'h0000_00C0);
    chk("R4 word1 kept", pin_out[63:32], 32'h0000_0001);
    rd(2, 0, v); chk("R3 set reads zero", v, 32'h0);
    rd(3, 0, v); chk("R4 clr reads zero", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk);
    pin_in[40] = 1'b1;
    @(posedge clk); #1;
    rd(0, 1, v); chk("R6 level after one edge", v, 32'h0);
    @(posedge clk); #1;
    rd(0, 1, v); chk("R6 level after two edges", v, 32'h0000_0100);
    wr(0, 1, 32'hFFFF_FFFF);
    rd(0, 1, v); chk("R12 level write ignored", v, 32'h0000_0100);
    chk("R12 pin_oe unchanged", pin_oe[63:32], 32'hA5A5_0001);
    chk("R12 pin_out unchanged", pin_out[63:32], 32'h0000_0001);
    rd(6, 1, v); chk("R12 status unchanged", v, 32'h0);
  endtask

  task automatic t_rising;
    logic [31:0] v;
    wr(4, 0, 32'h0000_0008);
    @(negedge clk);
    pin_in[3] = 1'b1;
    repeat (2) @(posedge clk); #1;
    rd(6, 0, v); chk("R7 no status before third edge", v, 32'h0);
    @(posedge clk); #1;
    rd(6, 0, v); chk("R7 rise captured", v, 32'h0000_0008);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    wr(6, 0, 32'h0000_0008);
    rd(6, 0, v); chk("R9 cleared", v, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b0;
    repeat (4) @(posedge clk); #1;
    rd(6, 0, v); chk("R7 falling ignored", v, 32'h0);
    @(negedge clk);
    pin_in[4] = 1'b1;
    repeat (4) @(posedge clk); #1;
    rd(6, 0, v); chk("R7 disabled pin ignored", v, 32'h0);
  endtask

  task automatic t_both_edges;
    logic [31:0] v;
    wr(4, 0, 32'h0000_0028);
    wr(5, 0, 32'h0000_0020);
    @(negedge clk); pin_in[5] = 1'b1;
    repeat (3) @(posedge clk); #1;
    rd(6, 0, v); chk("R8 rise with both", v, 32'h0000_0020);
    wr(6, 0, 32'h0000_0020);
    @(negedge clk); pin_in[5] = 1'b0;
    repeat (3) @(posedge clk); #1;
    rd(6, 0, v); chk("R8 fall with both", v, 32'h0000_0020);
    @(negedge clk); pin_in[3] = 1'b1;
    repeat (3) @(posedge clk); #1;
    rd(6, 0, v); chk("R8 two pins pending", v, 32'h0000_0028);
    wr(6, 0, 32'h0000_0008);
    rd(6, 0, v); chk("R9 zero bits untouched", v, 32'h0000_0020);
    chk("R10 irq stays with one left", {31'h0, irq}, 32'h1);
    wr(6, 0, 32'h0000_0020);
    chk("R10 irq drops when all clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(4, 1, 32'h0000_0080);
    wr(5, 1, 32'h0000_0080);
    @(negedge clk); pin_in[39] = 1'b1;
    repeat (3) @(posedge clk); #1;
    rd(6, 1, v); chk("R9 pre-collision set", v, 32'h0000_0080);
    @(negedge clk); pin_in[39] = 1'b0;
    @(negedge clk);
    wr(6, 1, 32'h0000_0080);
    rd(6, 1, v); chk("R9 edge during clear survives", v, 32'h0000_0080);
    chk("R10 irq held through collision", {31'h0, irq}, 32'h1);
    wr(6, 1, 32'h0000_0080);
    rd(6, 1, v); chk("R9 plain clear", v, 32'h0);
  endtask

  task automatic t_altfn;
    logic [31:0] v;
    wr(7, 1, 32'h0000_000C);
    chk("R11 pin17 field", {30'h0, altfn_sel[35:34]}, 32'h3);
    rd(7, 1, v); chk("R11 word1 readback", v, 32'h0000_000C);
    wr(7, 3, 32'h8000_0000);
    chk("R11 pin63 field", {30'h0, altfn_sel[127:126]}, 32'h2);
    rd(7, 3, v); chk("R11 word3 readback", v, 32'h8000_0000);
    rd(7, 0, v); chk("R11 word0 untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_set_clear();
    t_level();
    t_rising();
    t_both_edges();
    t_collision();
    t_altfn();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule